// File: doc/BRIEF.md
# Processor-to-Memory Word Transfer Unit

This block joins a processor-side access engine to a small byte-addressed memory. The two halves share an address bus that only the processor drives, a data bus that either side may drive, and three single-bit control lines: read, write and read-done. The processor side takes one command at a time through a valid/ready request port. It latches the address into a 64-bit address register and, for writes, the payload into a 64-bit data register. It then raises the read line or the write line.

On a read, the memory answers by fetching eight consecutive bytes, placing them on the data bus and raising read-done. Only then does the processor side copy the bus into its data register. The result leaves the block through a valid/ready response port. A write has no completion line and is treated as finished one cycle after the write line goes high.

The request port accepts a command only while `req_ready` is high. `req_ready` is low, and `busy` high, from the accepting edge until the transfer is complete. For a read, that means until the response has been taken. A request offered while busy simply waits and is not captured. The response port holds `rsp_valid` and `rsp_data` unchanged until `rsp_ready` is seen high at a clock edge. The bus signals are brought out as plain outputs so that the transfer can be observed.

Top module: `memxfer_top`

## Requirements
- R1: After reset, `req_ready` is 1, and `busy`, `rsp_valid`, `bus_rd`, `bus_wr`, `bus_rdone` and `bus_data` are all 0.
- R2: In the cycle after a read request is accepted, `bus_addr` equals the request address and `bus_rd` is 1. `bus_rd` stays 1 until `bus_rdone` has been seen at 1.
- R3: `bus_rdone` rises exactly one cycle after `bus_rd` rises. While it is high, `bus_data` carries the eight bytes starting at the read address, with the byte at the lowest address in bits 7:0 (little-endian).
- R4: The data register captures `bus_data` only when `bus_rdone` is 1. In the next cycle `bus_rd` is 0, `rsp_valid` is 1 and `rsp_data` holds the captured word. `bus_rdone` returns to 0 one cycle after `bus_rd` falls.
- R5: In the cycle after a write request is accepted, `bus_wr` is 1 for exactly one cycle, `bus_addr` equals the request address and `bus_data` carries the write data. In the next cycle `busy` is 0. The eight bytes are stored little-endian starting at that address.
- R6: A byte address selects the starting byte at any alignment. Byte positions are taken modulo the memory size of 128 bytes, so an access near the top of the array continues at byte 0.
- R7: The processor side drives `bus_data` only while `bus_wr` is 1, and the memory drives it only while `bus_rdone` is 1. The two are never high together, and `bus_data` reads 0 when neither drives it.
- R8: While `busy` is 1, `req_ready` is 0, and a request offered then is not accepted and has no effect on memory.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` stays 1 and `rsp_data` stays unchanged. `busy` stays 1 until the response is taken.
- R10: Reset clears every memory byte to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted at this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 64 | Byte address of first byte |
| req_wdata | input | 64 | Write payload, little-endian |
| rsp_valid | output | 1 | Read result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_data | output | 64 | Read result |
| busy | output | 1 | A transfer is in progress |
| bus_addr | output | 64 | Address bus (address register) |
| bus_data | output | 64 | Resolved data bus value |
| bus_rd | output | 1 | Read line |
| bus_wr | output | 1 | Write line |
| bus_rdone | output | 1 | Read-done line |

## Verification
Single read and write commands are traced cycle by cycle. This separates the read line, the read-done line and the capture into the data register, and shows a missing or extra cycle in either handshake. Streams of aligned, unaligned and wrap-around accesses are checked against a byte model. These distinguish lane-ordering mistakes from addressing mistakes. Runs with random and stalled response acceptance exercise back-pressure. A write offered while a read is stalled shows whether a busy unit leaks a request into memory.

// File: rtl/memxfer_pkg.sv
package memxfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_RSP  = 2'd3
  } xfer_st_t;
endpackage

// File: rtl/memxfer_cpu_side.sv
module memxfer_cpu_side
  import memxfer_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              busy,
  output logic [ADDR_W-1:0] addr_bus,
  output logic              rd_line,
  output logic              wr_line,
  input  logic              rdone_line,
  input  logic [DATA_W-1:0] data_bus,
  output logic [DATA_W-1:0] drv_data,
  output logic              drv_en
);
  xfer_st_t          state;
  logic [ADDR_W-1:0] addr_reg;
  logic [DATA_W-1:0] data_reg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      addr_reg <= '0;
      data_reg <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          addr_reg <= req_addr;
          data_reg <= req_wdata;
          state    <= req_write ? ST_WR : ST_RD;
        end
        ST_RD: if (rdone_line) begin
          data_reg <= data_bus;
          state    <= ST_RSP;
        end
        ST_WR:  state <= ST_IDLE;
        ST_RSP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign rd_line   = (state == ST_RD);
  assign wr_line   = (state == ST_WR);
  assign rsp_valid = (state == ST_RSP);
  assign rsp_data  = data_reg;
  assign addr_bus  = addr_reg;
  assign drv_data  = data_reg;
  assign drv_en    = wr_line;
endmodule

// File: rtl/memxfer_memory.sv
module memxfer_memory #(
  parameter int ADDR_W    = 64,
  parameter int DATA_W    = 64,
  parameter int MEM_BYTES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_bus,
  input  logic              rd_line,
  input  logic              wr_line,
  input  logic [DATA_W-1:0] data_bus,
  output logic              rdone_line,
  output logic [DATA_W-1:0] drv_data,
  output logic              drv_en
);
  localparam int IDX_W = $clog2(MEM_BYTES);
  localparam int LANES = DATA_W / 8;

  logic [7:0]       mem [MEM_BYTES];
  logic [IDX_W-1:0] lane_idx [LANES];
  logic [DATA_W-1:0] gathered;
  logic [DATA_W-1:0] rd_word;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_idx[g] = addr_bus[IDX_W-1:0] + IDX_W'(g);
    assign gathered[8*g +: 8] = mem[lane_idx[g]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
    end else if (wr_line) begin
      for (int l = 0; l < LANES; l++) mem[lane_idx[l]] <= data_bus[8*l +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdone_line <= 1'b0;
      rd_word    <= '0;
    end else if (rd_line && !rdone_line) begin
      rdone_line <= 1'b1;
      rd_word    <= gathered;
    end else if (!rd_line && rdone_line) begin
      rdone_line <= 1'b0;
    end
  end

  assign drv_data = rd_word;
  assign drv_en   = rdone_line;
endmodule

// File: rtl/memxfer_bus.sv
module memxfer_bus #(
  parameter int DATA_W = 64
) (
  input  logic              cpu_en,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              mem_en,
  input  logic [DATA_W-1:0] mem_data,
  output logic [DATA_W-1:0] bus
);
  always_comb begin
    bus = '0;
    if (cpu_en)      bus = cpu_data;
    else if (mem_en) bus = mem_data;
  end
endmodule

// File: rtl/memxfer_top.sv
module memxfer_top #(
  parameter int ADDR_W    = 64,
  parameter int DATA_W    = 64,
  parameter int MEM_BYTES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              busy,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              bus_rdone
);
  logic [DATA_W-1:0] cpu_drv, mem_drv;
  logic              cpu_en, mem_en;

  memxfer_cpu_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cpu (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .busy(busy), .addr_bus(bus_addr), .rd_line(bus_rd), .wr_line(bus_wr),
    .rdone_line(bus_rdone), .data_bus(bus_data),
    .drv_data(cpu_drv), .drv_en(cpu_en)
  );

  memxfer_memory #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_BYTES(MEM_BYTES)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .addr_bus(bus_addr), .rd_line(bus_rd), .wr_line(bus_wr),
    .data_bus(bus_data), .rdone_line(bus_rdone),
    .drv_data(mem_drv), .drv_en(mem_en)
  );

  memxfer_bus #(.DATA_W(DATA_W)) u_bus (
    .cpu_en(cpu_en), .cpu_data(cpu_drv),
    .mem_en(mem_en), .mem_data(mem_drv),
    .bus(bus_data)
  );
endmodule

// File: rtl/memxfer_checker.sv
module memxfer_checker #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              bus_rdone,
  input logic              busy,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data
);
  // R7
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rdone));
  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_rdone) |=> bus_rd);
  // R3
  rdone_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rdone) |-> $past(bus_rd));
  // R4
  rdone_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rd) |=> !bus_rdone);
  // R4
  capture_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(bus_rdone));
  // R5
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> !bus_wr);
  // R8
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

bind memxfer_top memxfer_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_rdone(bus_rdone), .busy(busy), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
);

// File: tb/test_memxfer_top.sv
`timescale 1ns/1ps
module test_memxfer_top;
  localparam int MB = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [63:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_data;
  logic        busy;
  logic [63:0] bus_addr, bus_data;
  logic        bus_rd, bus_wr, bus_rdone;

  int tests = 0;
  int fails = 0;
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0]  model [MB];
  logic [63:0] exp_q [$];

  always #2 clk = ~clk;

  memxfer_top i_memxfer_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .busy(busy), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdone(bus_rdone)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model_rd(input logic [63:0] a);
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[8*i +: 8] = model[(int'(a[6:0]) + i) % MB];
    return v;
  endfunction

  // response acceptance pattern
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rdy_mode)
      0: rsp_ready = 1'b1;
      1: rsp_ready = lfsr[0];
      default: rsp_ready = 1'b0;
    endcase
  end

  // monitor / scoreboard
  initial begin
    logic held = 1'b0;
    logic [63:0] held_data = '0;
    forever begin
      @(negedge clk); #1;
      if (held) begin
        chk("R9 rsp_valid held", {63'd0, rsp_valid}, 64'd1);
        chk("R9 rsp_data stable", rsp_data, held_data);
      end
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) chk("R4 unexpected response", rsp_data, 64'hX);
        else chk("R4/R6 read data", rsp_data, exp_q.pop_front());
      end
      held = rsp_valid && !rsp_ready;
      held_data = rsp_data;
    end
  end

  // driver: returns at the falling edge after the accepting edge
  task automatic issue(input bit wr, input logic [63:0] a, input logic [63:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    if (wr) begin
      for (int i = 0; i < 8; i++) model[(int'(a[6:0]) + i) % MB] = d[8*i +: 8];
    end else begin
      exp_q.push_back(model_rd(a));
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while ((exp_q.size() != 0 || busy) && n < 1000) begin @(negedge clk); n++; end
    #1;
  endtask

  task automatic trace_read(input logic [63:0] a);
    logic [63:0] e;
    e = model_rd(a);
    issue(0, a, 64'd0); #1;
    chk("R2 rd high", {63'd0, bus_rd}, 64'd1);
    chk("R2 addr bus", bus_addr, a);
    chk("R3 rdone not yet", {63'd0, bus_rdone}, 64'd0);
    chk("R9 busy", {63'd0, busy}, 64'd1);
    @(negedge clk); #1;
    chk("R2 rd held", {63'd0, bus_rd}, 64'd1);
    chk("R3 rdone high", {63'd0, bus_rdone}, 64'd1);
    chk("R3 data bus", bus_data, e);
    @(negedge clk); #1;
    chk("R4 rd low", {63'd0, bus_rd}, 64'd0);
    chk("R4 rdone still high", {63'd0, bus_rdone}, 64'd1);
    chk("R4 rsp_valid", {63'd0, rsp_valid}, 64'd1);
    @(negedge clk); #1;
    chk("R4 rdone low", {63'd0, bus_rdone}, 64'd0);
    chk("R7 idle bus", bus_data, 64'd0);
  endtask

  task automatic trace_write(input logic [63:0] a, input logic [63:0] d);
    issue(1, a, d); #1;
    chk("R5 wr high", {63'd0, bus_wr}, 64'd1);
    chk("R5 addr bus", bus_addr, a);
    chk("R5 data bus", bus_data, d);
    chk("R7 no rdone during wr", {63'd0, bus_rdone}, 64'd0);
    @(negedge clk); #1;
    chk("R5 wr pulse", {63'd0, bus_wr}, 64'd0);
    chk("R5 not busy", {63'd0, busy}, 64'd0);
    chk("R7 idle bus", bus_data, 64'd0);
  endtask

  initial begin
    #(4 * 150000);
    chk("watchdog expired", 64'd1, 64'd0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < MB; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 req_ready", {63'd0, req_ready}, 64'd1);
    chk("R1 busy", {63'd0, busy}, 64'd0);
    chk("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
    chk("R1 lines", {61'd0, bus_rd, bus_wr, bus_rdone}, 64'd0);
    chk("R1 data bus", bus_data, 64'd0);

    // R10 cleared memory
    trace_read(64'd40);
    wait_idle();

    trace_write(64'd8, 64'h8877665544332211);
    trace_read(64'd8);
    wait_idle();
    // R5 little-endian: byte at address 8 is LSB
    issue(0, 64'd8, 0); wait_idle();
    issue(0, 64'd9, 0); wait_idle();

    // R6 unaligned and wrap-around
    trace_write(64'd3, 64'hDEADBEEFCAFEF00D);
    issue(0, 64'd5, 0);
    issue(0, 64'd0, 0);
    trace_write(64'd125, 64'h0102030405060708);
    issue(0, 64'd124, 0);
    issue(0, 64'd0, 0);
    issue(0, 64'hFFFF_0000_0000_007E, 0);
    wait_idle();

    // random stream with random acceptance
    rdy_mode = 1;
    for (int k = 0; k < 40; k++) begin
      logic [63:0] a, d;
      a = {$urandom, $urandom};
      d = {$urandom, $urandom};
      issue(k % 3 == 0 ? 1'b0 : 1'b1, a, d);
      if (k % 2 == 0) issue(0, a + 64'd2, 0);
    end
    wait_idle();

    // R8 request during a stalled read is ignored
    rdy_mode = 2;
    issue(0, 64'd64, 0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 64'd64; req_wdata = 64'h5A5A5A5A5A5A5A5A;
    for (int c = 0; c < 6; c++) begin
      #1;
      chk("R8 req_ready low while busy", {63'd0, req_ready}, 64'd0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    rdy_mode = 0;
    wait_idle();
    issue(0, 64'd64, 0);
    wait_idle();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule